// File: doc/BRIEF.md
# TDM Slot Selector with Key-Word Receive Filter

This block holds the slot-control logic for a time-division-multiplexed serial frame. The frame has from 1 to 32 fixed-length channels. A frame-sync pulse starts the frame. After a programmable number of serial bit periods, the data phase begins at channel 0. From then on, each word-complete strobe from an external shifter moves the slot index to the next channel. The index wraps modulo the programmed channel count.

Two per-slot masks control the data path:
- The transmit mask decides in which slots the transmit data output is driven (output enable high) and in which it is released.
- The receive mask decides which received words are considered at all.

For receive slots chosen by a separate compare-select mask, a masked key-word comparator filters the word. The comparator passes either only matching words or only non-matching words. An accepted word is presented together with its slot number and a one-cycle receive request. A rejected word disappears without any request.

The block does no bit shifting, companding or memory transfer. The shifter next to it gives it a serial bit-period strobe, the word-complete strobe and the received word.

Top module: `tdm_slot_sel`

## Requirements
- R1: While reset is asserted and after its release, before any frame sync: `curSlot` is 0, and `slotsLive`, `txOe`, `txValid` and `rxReq` are all 0.
- R2: A frame sync sets `curSlot` to 0 on the next cycle. This holds also when the sync arrives in the middle of a frame.
- R3: Each accepted word-complete strobe in the data phase advances `curSlot` by one. After slot `chanCountM1` (channel count minus one), the index wraps to 0.
- R4: After a frame sync, `slotsLive` rises only after `frameDelay` bit-tick strobes. A value of 0 makes it rise together with the sync. Word-complete strobes before that do not move the slot and raise no request.
- R5: `txOe` is 1 only in the data phase, and only while bit n of `txEnMask` is 1, where n is `curSlot`.
- R6: `txValid` pulses for one cycle, the cycle after a word completes, if and only if `txOe` was 1 when that word completed.
- R7: A word completing in a slot whose `rxEnMask` bit is 0 raises no `rxReq`.
- R8: A received word matches when it equals `keyWord` in every bit position where `keyMask` is 0. Bits where `keyMask` is 1 are ignored.
- R9: The filter control works as follows. With `filtEn`=0, every word is accepted. With `filtEn`=1 and `filtSense`=0, only non-matching words are accepted. With `filtEn`=1 and `filtSense`=1, only matching words are accepted.
- R10: Receive-enabled slots whose `cmpSelMask` bit is 0 accept every word, whatever the filter mode.
- R11: An accepted word raises `rxReq` for one cycle, the cycle after its word-complete strobe. In that cycle `rxData` holds the word and `rxSlot` holds the slot in which it completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | One-cycle frame-start pulse |
| bitTick | input | 1 | One-cycle strobe per serial bit period |
| wordDone | input | 1 | Word-complete strobe from the shifter |
| rxWordIn | input | 32 | Word received by the shifter, valid with wordDone |
| chanCountM1 | input | 5 | Number of channels minus one |
| frameDelay | input | 4 | Bit periods from frame sync to first data bit |
| txEnMask | input | 32 | Per-slot transmit enable |
| rxEnMask | input | 32 | Per-slot receive enable |
| cmpSelMask | input | 32 | Per-slot key-filter select |
| keyWord | input | 32 | Comparison key |
| keyMask | input | 32 | 1 = bit excluded from comparison |
| filtEn | input | 1 | Key filter enable |
| filtSense | input | 1 | 1 = accept on match, 0 = accept on mismatch |
| curSlot | output | 5 | Current slot index |
| slotsLive | output | 1 | Data phase of the frame is running |
| txOe | output | 1 | Transmit data output enable |
| txValid | output | 1 | Pulse: a word was driven in an enabled slot |
| rxReq | output | 1 | Pulse: an accepted word is presented |
| rxData | output | 32 | Accepted word |
| rxSlot | output | 5 | Slot of the accepted word |

## Verification
The hardest situation to reach is a slot in which the receive and compare masks overlap, with the filter sense flipped between frames. The only way to reach a given slot is to step the whole frame with word strobes after a sync and its delay.

The stimulus first walks a four-channel frame through its wrap. It then uses mid-frame syncs to jump back to slot 0 under each filter mode. In each mode it offers words that differ from the key only in masked bits, and words that differ in compared bits.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int MAX_CH = 32;
  localparam int SLOT_W = $clog2(MAX_CH);

  typedef logic [SLOT_W-1:0] slotIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     live;      // data phase running
    logic     wordTake;  // word completed inside the data phase
    slotIdx_t slot;      // slot index for this cycle
  } slotStrobes_t;
endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_slot_pkg::*;
#(
  parameter int DELAY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameSync,
  input  logic               bitTick,
  input  logic               wordDone,
  input  slotIdx_t           chanCountM1,
  input  logic [DELAY_W-1:0] frameDelay,
  output slotStrobes_t       strobes
);
  logic               running;
  logic [DELAY_W-1:0] delayCnt;
  slotIdx_t           slotIdx;
  logic               live;
  logic               lastSlot;

  assign live     = running && (delayCnt == '0);
  assign lastSlot = (slotIdx >= chanCountM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      delayCnt <= '0;
      slotIdx  <= '0;
    end else if (frameSync) begin
      running  <= 1'b1;
      delayCnt <= frameDelay;
      slotIdx  <= '0;
    end else begin
      if (bitTick && running && (delayCnt != '0))
        delayCnt <= delayCnt - 1'b1;
      if (wordDone && live)
        slotIdx <= lastSlot ? '0 : slotIdx + 1'b1;
    end
  end

  always_comb begin
    strobes.live     = live;
    strobes.wordTake = wordDone && live && !frameSync;
    strobes.slot     = slotIdx;
  end
endmodule

// File: rtl/tdm_slot_dp.sv
module tdm_slot_dp
  import tdm_slot_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrobes_t      strobes,
  input  logic [WORD_W-1:0] rxWordIn,
  input  logic [MAX_CH-1:0] txEnMask,
  input  logic [MAX_CH-1:0] rxEnMask,
  input  logic [MAX_CH-1:0] cmpSelMask,
  input  logic [WORD_W-1:0] keyWord,
  input  logic [WORD_W-1:0] keyMask,
  input  logic              filtEn,
  input  logic              filtSense,
  output logic              txOe,
  output logic              txValid,
  output logic              rxReq,
  output logic [WORD_W-1:0] rxData,
  output slotIdx_t          rxSlot
);
  logic [WORD_W-1:0] diffBits;
  logic              keyHit;
  logic              filterPass;
  logic              slotRxOn;
  logic              accept;

  // compare only bits whose mask bit is 0
  assign diffBits = (rxWordIn ^ keyWord) & ~keyMask;
  assign keyHit   = (diffBits == '0);

  always_comb begin
    if (!filtEn || !cmpSelMask[strobes.slot]) filterPass = 1'b1;
    else if (filtSense)                       filterPass = keyHit;
    else                                      filterPass = !keyHit;
  end

  assign slotRxOn = rxEnMask[strobes.slot];
  assign accept   = strobes.wordTake && slotRxOn && filterPass;
  assign txOe     = strobes.live && txEnMask[strobes.slot];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      rxReq   <= 1'b0;
      rxData  <= '0;
      rxSlot  <= '0;
    end else begin
      txValid <= strobes.wordTake && txOe;
      rxReq   <= accept;
      if (accept) begin
        rxData <= rxWordIn;
        rxSlot <= strobes.slot;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_sel.sv
module tdm_slot_sel
  import tdm_slot_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int DELAY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameSync,
  input  logic               bitTick,
  input  logic               wordDone,
  input  logic [WORD_W-1:0]  rxWordIn,
  input  logic [SLOT_W-1:0]  chanCountM1,
  input  logic [DELAY_W-1:0] frameDelay,
  input  logic [MAX_CH-1:0]  txEnMask,
  input  logic [MAX_CH-1:0]  rxEnMask,
  input  logic [MAX_CH-1:0]  cmpSelMask,
  input  logic [WORD_W-1:0]  keyWord,
  input  logic [WORD_W-1:0]  keyMask,
  input  logic               filtEn,
  input  logic               filtSense,
  output logic [SLOT_W-1:0]  curSlot,
  output logic               slotsLive,
  output logic               txOe,
  output logic               txValid,
  output logic               rxReq,
  output logic [WORD_W-1:0]  rxData,
  output logic [SLOT_W-1:0]  rxSlot
);
  slotStrobes_t strobes;

  tdm_slot_ctrl #(.DELAY_W(DELAY_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameSync   (frameSync),
    .bitTick     (bitTick),
    .wordDone    (wordDone),
    .chanCountM1 (chanCountM1),
    .frameDelay  (frameDelay),
    .strobes     (strobes)
  );

  tdm_slot_dp #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rxWordIn   (rxWordIn),
    .txEnMask   (txEnMask),
    .rxEnMask   (rxEnMask),
    .cmpSelMask (cmpSelMask),
    .keyWord    (keyWord),
    .keyMask    (keyMask),
    .filtEn     (filtEn),
    .filtSense  (filtSense),
    .txOe       (txOe),
    .txValid    (txValid),
    .rxReq      (rxReq),
    .rxData     (rxData),
    .rxSlot     (rxSlot)
  );

  assign curSlot   = strobes.slot;
  assign slotsLive = strobes.live;
endmodule

// File: rtl/tdm_slot_sel_chk.sv
module tdm_slot_sel_chk
  import tdm_slot_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             frameSync,
  input logic             wordDone,
  input logic [SLOT_W-1:0] chanCountM1,
  input logic [SLOT_W-1:0] curSlot,
  input logic             slotsLive,
  input logic             txOe,
  input logic             txValid,
  input logic             rxReq
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (curSlot == '0 && !rxReq && !txValid && !slotsLive));

  // R2
  a_r2_sync_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (curSlot == '0));

  // R3
  a_r3_wrap_at_last: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && slotsLive && !frameSync && curSlot == chanCountM1) |=> (curSlot == '0));

  // R5
  a_r5_tx_only_live: assert property (@(posedge clk) disable iff (!rstN)
    txOe |-> slotsLive);

  // R6
  a_r6_valid_follows_drive: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(wordDone && txOe));

  // R11
  a_r11_req_follows_word: assert property (@(posedge clk) disable iff (!rstN)
    rxReq |-> $past(wordDone && slotsLive && !frameSync));
endmodule

bind tdm_slot_sel tdm_slot_sel_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameSync   (frameSync),
  .wordDone    (wordDone),
  .chanCountM1 (chanCountM1),
  .curSlot     (curSlot),
  .slotsLive   (slotsLive),
  .txOe        (txOe),
  .txValid     (txValid),
  .rxReq       (rxReq)
);

// File: tb/tdm_slot_sel_tb.sv
module tdm_slot_sel_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        frameSync, bitTick, wordDone;
  logic [31:0] rxWordIn;
  logic [4:0]  chanCountM1;
  logic [3:0]  frameDelay;
  logic [31:0] txEnMask, rxEnMask, cmpSelMask, keyWord, keyMask;
  logic        filtEn, filtSense;
  logic [4:0]  curSlot, rxSlot;
  logic        slotsLive, txOe, txValid, rxReq;
  logic [31:0] rxData;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tdm_slot_sel u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .bitTick(bitTick),
    .wordDone(wordDone), .rxWordIn(rxWordIn), .chanCountM1(chanCountM1),
    .frameDelay(frameDelay), .txEnMask(txEnMask), .rxEnMask(rxEnMask),
    .cmpSelMask(cmpSelMask), .keyWord(keyWord), .keyMask(keyMask),
    .filtEn(filtEn), .filtSense(filtSense), .curSlot(curSlot),
    .slotsLive(slotsLive), .txOe(txOe), .txValid(txValid), .rxReq(rxReq),
    .rxData(rxData), .rxSlot(rxSlot)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulseSync();
    frameSync = 1'b1;
    @(posedge clk); #1;
    frameSync = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      @(posedge clk); #1;
      bitTick = 1'b0;
    end
  endtask

  // one word; checks drive state before and strobes/slot after
  task automatic word(input logic [31:0] d, input logic expOe, input logic expReq,
                      input logic [4:0] expSlot, input string tag);
    logic [4:0] slotNow;
    slotNow = curSlot;
    chk({tag, " R5 txOe"}, {31'd0, txOe}, {31'd0, expOe});
    rxWordIn = d;
    wordDone = 1'b1;
    @(posedge clk); #1;
    wordDone = 1'b0;
    chk({tag, " R6 txValid"}, {31'd0, txValid}, {31'd0, expOe});
    chk({tag, " R7/R9 rxReq"}, {31'd0, rxReq}, {31'd0, expReq});
    chk({tag, " R3 curSlot"}, {27'd0, curSlot}, {27'd0, expSlot});
    if (expReq) begin
      chk({tag, " R11 rxData"}, rxData, d);
      chk({tag, " R11 rxSlot"}, {27'd0, rxSlot}, {27'd0, slotNow});
    end
  endtask

  task automatic testReset();
    chk("R1 curSlot", {27'd0, curSlot}, 32'd0);
    chk("R1 slotsLive", {31'd0, slotsLive}, 32'd0);
    chk("R1 txOe", {31'd0, txOe}, 32'd0);
    chk("R1 rxReq", {31'd0, rxReq}, 32'd0);
    chk("R1 txValid", {31'd0, txValid}, 32'd0);
  endtask

  task automatic testDelay();
    frameDelay = 4'd2;
    pulseSync();
    chk("R2 slot after sync", {27'd0, curSlot}, 32'd0);
    chk("R4 not live at sync", {31'd0, slotsLive}, 32'd0);
    word(32'hA5A5_0001, 1'b0, 1'b0, 5'd0, "R4 early word");
    ticks(1);
    chk("R4 not live after 1 tick", {31'd0, slotsLive}, 32'd0);
    ticks(1);
    chk("R4 live after 2 ticks", {31'd0, slotsLive}, 32'd1);
  endtask

  task automatic testWalk();
    word(32'hA5A5_1234, 1'b0, 1'b1, 5'd1, "R8 slot0 masked match");
    word(32'h1111_1111, 1'b1, 1'b0, 5'd2, "R7 slot1 rx off");
    word(32'h0BAD_F00D, 1'b1, 1'b1, 5'd3, "R10 slot2 no compare");
    word(32'hA5A5_0000, 1'b0, 1'b0, 5'd0, "R3 slot3 wrap");
    word(32'h5A5A_1234, 1'b0, 1'b0, 5'd1, "R9 match mode reject");
  endtask

  task automatic testMismatchMode();
    frameDelay = 4'd0;
    filtSense  = 1'b0;
    pulseSync();
    chk("R2 mid-frame sync", {27'd0, curSlot}, 32'd0);
    chk("R4 zero delay live", {31'd0, slotsLive}, 32'd1);
    word(32'h5A5A_0000, 1'b0, 1'b1, 5'd1, "R9 mismatch accept");
    pulseSync();
    word(32'hA5A5_FFFF, 1'b0, 1'b0, 5'd1, "R8 R9 match rejected");
  endtask

  task automatic testFilterOff();
    filtEn = 1'b0;
    pulseSync();
    word(32'h0000_0042, 1'b0, 1'b1, 5'd1, "R9 filter off");
  endtask

  task automatic testSingleChannel();
    chanCountM1 = 5'd0;
    pulseSync();
    word(32'h0000_0001, 1'b0, 1'b1, 5'd0, "R3 single ch a");
    word(32'h0000_0002, 1'b0, 1'b1, 5'd0, "R3 single ch b");
  endtask

  initial begin
    rstN = 1'b0; frameSync = 1'b0; bitTick = 1'b0; wordDone = 1'b0;
    rxWordIn = '0; chanCountM1 = 5'd3; frameDelay = 4'd0;
    txEnMask = 32'b0110; rxEnMask = 32'b0101; cmpSelMask = 32'b0001;
    keyWord = 32'hA5A5_0000; keyMask = 32'h0000_FFFF;
    filtEn = 1'b1; filtSense = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testDelay();
    testWalk();
    testMismatchMode();
    testFilterOff();
    testSingleChannel();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule